// File: doc/BRIEF.md
# Segmented Base-and-Limit Address Translator

This block maps effective addresses onto physical memory for a core that keeps its code and its data in two separate segments. Each segment is described by a base and a limit. An instruction fetch is relocated by the code segment's base and checked against the code limit. A load or store uses the data segment's pair instead. The physical address is the selected base plus the effective address. An access is out of range when its effective address is not below the selected limit, so the limit acts as the segment length.

Results are registered, so the physical address, the valid qualifier and the fault flag appear one cycle after the request. An out-of-range access never produces a valid address. The four segment registers are loaded through a small write port. That port accepts writes only while the core is in supervisor mode. A write attempted from user mode is dropped, and it produces a one-cycle privilege-error pulse instead. Reset clears all four registers, so every access faults until software programs the segments.

Top module: `seg_xlate`

## Requirements
- R1: After reset all four segment registers are zero, and `xl_valid`, `xl_fault`, `xl_pa` and `priv_err` are low. Every request made before any register is written faults.
- R2: One cycle after a request with `req_valid` high, `xl_pa` equals the selected base plus `req_ea`, computed AW+1 bits wide with no wrap, whenever `xl_valid` is high.
- R3: One cycle after a request, `xl_valid` is high when `req_ea` is below the selected limit, and `xl_fault` is high when `req_ea` is greater than or equal to it. The two are never high together. Both are low one cycle after a cycle with no request.
- R4: `req_fetch` high selects the code base and code limit. `req_fetch` low selects the data base and data limit.
- R5: A write with `wr_en` and `priv_sup` high loads `wr_data` into the register chosen by `wr_sel`: 0 selects the code base, 1 the code limit, 2 the data base and 3 the data limit. The new value governs requests from the next cycle on.
- R6: A write with `wr_en` high and `priv_sup` low changes no segment register, and `priv_err` is high for exactly the following cycle. `priv_err` is low after a supervisor write.
- R7: `xl_pa` is zero whenever `xl_valid` is low.
- R8: A limit of zero makes every access to that segment fault. A limit of all ones admits every effective address except the all-ones address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = load/store |
| req_ea | input | AW | Effective address |
| priv_sup | input | 1 | Core is in supervisor mode |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Register select (0 code base, 1 code limit, 2 data base, 3 data limit) |
| wr_data | input | AW | Value to write |
| xl_valid | output | 1 | Translated address is usable |
| xl_fault | output | 1 | Access was outside its segment |
| xl_pa | output | AW+1 | Physical address |
| priv_err | output | 1 | A user-mode register write was rejected |

## Verification
Each test point programs the code and data pairs with deliberately different bases and limits. It then sweeps every effective address through fetches and through data accesses. A swapped pair selection therefore shows up as wrong sums or wrong faults. Limits are swept from zero to all ones, which tells apart a strict less-than bound from an off-by-one at the boundary address. Bases up to all ones expose a truncated carry in the sum. Writes issued in user mode are followed by the same sweeps. This shows the segments kept their values, and that only the privilege pulse changed.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_fetch,
  input  logic [AW-1:0] req_ea,
  input  logic          priv_sup,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic          xl_valid,
  output logic          xl_fault,
  output logic [AW:0]   xl_pa,
  output logic          priv_err
);
  localparam int PW = AW + 1;

  logic [AW-1:0] code_base, code_lim, data_base, data_lim;

  wire wr_ok = wr_en & priv_sup;
  wire wr_bad = wr_en & ~priv_sup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_base <= '0;
      code_lim  <= '0;
      data_base <= '0;
      data_lim  <= '0;
    end else if (wr_ok) begin
      case (wr_sel)
        2'd0: code_base <= wr_data;
        2'd1: code_lim  <= wr_data;
        2'd2: data_base <= wr_data;
        default: data_lim <= wr_data;
      endcase
    end
  end

  wire [AW-1:0] seg_base = req_fetch ? code_base : data_base;
  wire [AW-1:0] seg_lim  = req_fetch ? code_lim  : data_lim;
  wire          in_seg   = req_ea < seg_lim;
  wire [PW-1:0] sum      = {1'b0, seg_base} + {1'b0, req_ea};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_valid <= 1'b0;
      xl_fault <= 1'b0;
      xl_pa    <= '0;
      priv_err <= 1'b0;
    end else begin
      xl_valid <= req_valid & in_seg;
      xl_fault <= req_valid & ~in_seg;
      xl_pa    <= (req_valid & in_seg) ? sum : '0;
      priv_err <= wr_bad;
    end
  end

  AST_VALID_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_valid && xl_fault)); // R3
  AST_RESULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid || xl_fault) |-> $past(req_valid)); // R3
  AST_PA_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_valid |-> (xl_pa == '0)); // R7
  AST_USER_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !priv_sup) |=> ($stable(code_base) && $stable(code_lim)
                              && $stable(data_base) && $stable(data_lim))); // R6
  AST_PRIV_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    priv_err |-> $past(wr_en && !priv_sup)); // R6
  AST_ZERO_LIMIT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch && code_lim == '0) |=> xl_fault); // R8
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  localparam int AW = 4;
  localparam int N = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_fetch = 0, priv_sup = 0, wr_en = 0;
  logic [AW-1:0] req_ea = '0, wr_data = '0;
  logic [1:0] wr_sel = '0;
  logic xl_valid, xl_fault, priv_err;
  logic [AW:0] xl_pa;

  int checks = 0, errors = 0;
  int m_cb = 0, m_cl = 0, m_db = 0, m_dl = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_xlate #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
    .req_ea(req_ea), .priv_sup(priv_sup), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .xl_valid(xl_valid), .xl_fault(xl_fault),
    .xl_pa(xl_pa), .priv_err(priv_err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int val, input bit sup);
    wr_en = 1; wr_sel = sel[1:0]; wr_data = val[AW-1:0]; priv_sup = sup;
    @(negedge clk);
    wr_en = 0; priv_sup = 0;
    chk(sup ? "R5 priv_err after supervisor write" : "R6 priv_err after user write",
        int'(priv_err), sup ? 0 : 1);
    if (sup) begin
      case (sel)
        0: m_cb = val; 1: m_cl = val; 2: m_db = val; default: m_dl = val;
      endcase
    end
  endtask

  task automatic acc(input bit f, input int ea, input string tag);
    int b, l;
    bit ok;
    b = f ? m_cb : m_db;
    l = f ? m_cl : m_dl;
    ok = ea < l;
    req_valid = 1; req_fetch = f; req_ea = ea[AW-1:0];
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R3 valid"}, int'(xl_valid), int'(ok));
    chk({tag, " R3 fault"}, int'(xl_fault), int'(!ok));
    chk({tag, f ? " R4 code R2/R7 pa" : " R4 data R2/R7 pa"}, int'(xl_pa), ok ? b + ea : 0);
  endtask

  task automatic sweep(input string tag);
    for (int f = 0; f < 2; f++)
      for (int ea = 0; ea < N; ea++) acc(f[0], ea, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset valid", int'(xl_valid), 0);
    chk("R1 reset fault", int'(xl_fault), 0);
    chk("R1 reset pa", int'(xl_pa), 0);
    chk("R1 reset priv_err", int'(priv_err), 0);
    sweep("R1 unprogrammed");
    @(negedge clk);
    chk("R3 idle valid", int'(xl_valid), 0);
    chk("R3 idle fault", int'(xl_fault), 0);
    for (int bi = 0; bi < 3; bi++) begin
      for (int lim = 0; lim < N; lim++) begin
        int b;
        b = (bi == 0) ? 0 : (bi == 1) ? 5 : N - 1;
        wr(0, b, 1);
        wr(1, lim, 1);
        wr(2, (b ^ 9) & (N - 1), 1);
        wr(3, N - 1 - lim, 1);
        sweep((lim == 0 || lim == N - 1) ? "R8 limit edge" : "R5 sweep");
      end
    end
    wr(0, 3, 1); wr(1, 7, 1); wr(2, 12, 1); wr(3, 10, 1);
    for (int s = 0; s < 4; s++) wr(s, 1, 0);
    sweep("R6 after user writes");
    wr(1, 0, 1);
    acc(1, 0, "R8 zero limit");
    wr(1, N - 1, 1);
    acc(1, N - 2, "R8 max limit in");
    acc(1, N - 1, "R8 max limit out");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule